// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the two edge streams that drive a phase-frequency detector: the divided reference and the divided feedback. It raises an active-high lock flag once the loop has settled. Both streams arrive as single-cycle pulses that are already synchronous to a fast sampling clock. For each pair of edges, the block counts the sampling-clock periods from the first edge to the second, whichever input leads. That count is the phase error of that detector cycle.

The flag uses hysteresis. It is set only after a run of consecutive pairs whose error is below a tight lock threshold. The run is three pairs in normal precision and five in high precision. Once set, the flag drops only when one pair shows an error above a looser unlock threshold. Errors between the two thresholds are tolerated while locked.

A missing partner edge counts as a large error. So does a leader that repeats before its partner arrives. Both cases are a frequency error, not a phase error.

Top module: `pll_lock_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `locked` goes low and the good-pair count returns to zero. After reset, `locked` stays low until a full run of good pairs has been seen.
- R2: The phase error of a pair is the number of sampling-clock cycles from the leading edge pulse to the partner pulse. Either input may lead. Pulses on both inputs in the same cycle give an error of 0.
- R3: With `precise` = 0, `locked` rises after 3 consecutive pairs whose error is below LOCK_THR (default 4 counts). It is high by the second clock edge after the third partner pulse, and it is still low after only 2 good pairs.
- R4: With `precise` = 1, 5 consecutive good pairs are needed, and `locked` is still low after 4 good pairs.
- R5: While unlocked, a pair with error at or above LOCK_THR resets the good-pair run to zero, so that a full new run is needed.
- R6: While locked, any single pair with error above UNLOCK_THR (default 6 counts) clears `locked`.
- R7: While locked, pairs with error from LOCK_THR up to and including UNLOCK_THR leave `locked` high.
- R8: If the partner pulse has not arrived TIMEOUT cycles (default 32) after a leading pulse, the pair is ended and graded as a large error. Before that point, `locked` is not affected.
- R9: A second pulse on the leading input before the partner arrives ends the pair as a large error. That second pulse does not start a new pair.
- R10: After an unlock, `locked` stays low until a fresh full run of good pairs has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_edge | input | 1 | Single-cycle pulse for each reference edge |
| fb_edge | input | 1 | Single-cycle pulse for each feedback edge |
| precise | input | 1 | 0: three good pairs to lock, 1: five good pairs |
| locked | output | 1 | Registered active-high lock flag |

## Verification
The assertions check on every cycle the following:
- the flag rises only on a good measurement and falls only on a bad one;
- an in-between measurement never drops a held lock;
- the good-pair run never passes the high-precision target;
- a pending pair that reaches the timeout is closed as a fault.

Only the directed scenarios show the end-to-end behaviour at the pins:
- the exact run lengths for each precision;
- the reset of the run by a mid-range error;
- the threshold boundaries at 3/4 and 6/7 counts with either input leading;
- the timing of the timeout and of the repeated-leader cases;
- the need for a fresh run after unlock.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    GR_GOOD = 2'd0,
    GR_MID  = 2'd1,
    GR_BAD  = 2'd2
  } grade_t;
endpackage

// File: rtl/pld_phase_meter.sv
module pld_phase_meter #(
  parameter int TIMEOUT = 32,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_edge,
  input  logic          fb_edge,
  output logic          meas_valid,
  output logic [CW-1:0] meas_err,
  output logic          meas_fault
);
  localparam logic [CW-1:0] TMO = CW'(TIMEOUT);

  logic          waiting;
  logic          lead_ref;
  logic [CW-1:0] cnt;
  logic          partner_hit;
  logic          leader_again;

  always_comb begin
    partner_hit  = lead_ref ? fb_edge  : ref_edge;
    leader_again = lead_ref ? ref_edge : fb_edge;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      waiting    <= 1'b0;
      lead_ref   <= 1'b0;
      cnt        <= '0;
      meas_valid <= 1'b0;
      meas_err   <= '0;
      meas_fault <= 1'b0;
    end else begin
      meas_valid <= 1'b0;
      meas_fault <= 1'b0;
      if (!waiting) begin
        if (ref_edge && fb_edge) begin
          meas_valid <= 1'b1;
          meas_err   <= '0;
        end else if (ref_edge || fb_edge) begin
          waiting  <= 1'b1;
          lead_ref <= ref_edge;
          cnt      <= CW'(1);
        end
      end else if (partner_hit) begin
        meas_valid <= 1'b1;
        meas_err   <= cnt;
        waiting    <= 1'b0;
      end else if (leader_again || cnt == TMO) begin
        meas_valid <= 1'b1;
        meas_fault <= 1'b1;
        meas_err   <= cnt;
        waiting    <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R8: a pending pair that reaches the timeout is closed as a fault
  p_timeout_fault_r8: assert property (@(posedge clk) disable iff (rst)
    (waiting && cnt == TMO && !ref_edge && !fb_edge) |=> (meas_valid && meas_fault));

  // R2: a measured error never exceeds the timeout window
  p_err_bound_r2: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (meas_err <= TMO));

  // R9: a repeated leader with no partner ends the pair as a fault
  p_repeat_fault_r9: assert property (@(posedge clk) disable iff (rst)
    (waiting && leader_again && !partner_hit) |=> (meas_valid && meas_fault && !waiting));
endmodule

// File: rtl/pld_grader.sv
module pld_grader
  import pld_pkg::*;
#(
  parameter int LOCK_THR   = 4,
  parameter int UNLOCK_THR = 6,
  parameter int CW         = 6
) (
  input  logic [CW-1:0] err,
  input  logic          fault,
  output grade_t        grade
);
  localparam logic [CW-1:0] LK = CW'(LOCK_THR);
  localparam logic [CW-1:0] UL = CW'(UNLOCK_THR);

  always_comb begin
    if (fault || err > UL) grade = GR_BAD;
    else if (err < LK)     grade = GR_GOOD;
    else                   grade = GR_MID;
  end
endmodule

// File: rtl/pld_lock_ctrl.sv
module pld_lock_ctrl
  import pld_pkg::*;
#(
  parameter int GOOD_LO = 3,
  parameter int GOOD_HI = 5,
  localparam int GW = $clog2(GOOD_HI + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   meas_valid,
  input  grade_t grade,
  input  logic   precise,
  output logic   locked
);
  logic [GW-1:0] good_cnt;
  logic [GW:0]   cnt_next;
  logic [GW:0]   need;

  always_comb begin
    cnt_next = {1'b0, good_cnt} + (GW+1)'(1);
    need     = precise ? (GW+1)'(GOOD_HI) : (GW+1)'(GOOD_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      good_cnt <= '0;
    end else if (meas_valid) begin
      if (locked) begin
        if (grade == GR_BAD) begin
          locked   <= 1'b0;
          good_cnt <= '0;
        end
      end else if (grade == GR_GOOD) begin
        if (cnt_next >= need) begin
          locked   <= 1'b1;
          good_cnt <= '0;
        end else begin
          good_cnt <= cnt_next[GW-1:0];
        end
      end else begin
        good_cnt <= '0;
      end
    end
  end

  // R1: reset clears flag and run
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!locked && good_cnt == '0));

  // R3: lock rises only on a good measurement
  p_rise_on_good_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(meas_valid && grade == GR_GOOD));

  // R6: lock falls only on a bad measurement
  p_fall_on_bad_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(meas_valid && grade == GR_BAD));

  // R7: a non-bad measurement keeps a held lock
  p_hold_mid_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && meas_valid && grade != GR_BAD) |=> locked);

  // R4: the run never reaches the high-precision target while counting
  p_run_bound_r4: assert property (@(posedge clk) disable iff (rst)
    good_cnt < GW'(GOOD_HI));
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector
  import pld_pkg::*;
#(
  parameter int LOCK_THR   = 4,
  parameter int UNLOCK_THR = 6,
  parameter int TIMEOUT    = 32,
  parameter int GOOD_LO    = 3,
  parameter int GOOD_HI    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_edge,
  input  logic fb_edge,
  input  logic precise,
  output logic locked
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          meas_valid;
  logic [CW-1:0] meas_err;
  logic          meas_fault;
  grade_t        grade;

  pld_phase_meter #(.TIMEOUT(TIMEOUT)) u_meter (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .meas_valid(meas_valid), .meas_err(meas_err), .meas_fault(meas_fault)
  );

  pld_grader #(.LOCK_THR(LOCK_THR), .UNLOCK_THR(UNLOCK_THR), .CW(CW)) u_grade (
    .err(meas_err), .fault(meas_fault), .grade(grade)
  );

  pld_lock_ctrl #(.GOOD_LO(GOOD_LO), .GOOD_HI(GOOD_HI)) u_ctrl (
    .clk(clk), .rst(rst), .meas_valid(meas_valid), .grade(grade),
    .precise(precise), .locked(locked)
  );
endmodule

// File: tb/sim_pll_lock_detector.sv
module sim_pll_lock_detector;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_edge = 1'b0;
  logic fb_edge = 1'b0;
  logic precise = 1'b0;
  logic locked;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_lock_detector u0 (
    .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .precise(precise), .locked(locked)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (locked !== exp) begin
      failures++;
      $display("FAIL %s locked=%b expected=%b at %0t", req, locked, exp, $time);
    end
  endtask

  task automatic do_reset(input logic prec);
    @(negedge clk);
    rst = 1'b1; precise = prec; ref_edge = 1'b0; fb_edge = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pair(input bit ref_first, input int gap);
    @(negedge clk);
    if (gap == 0) begin
      ref_edge = 1'b1; fb_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
    end else begin
      if (ref_first) ref_edge = 1'b1; else fb_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
      repeat (gap - 1) @(negedge clk);
      if (ref_first) fb_edge = 1'b1; else ref_edge = 1'b1;
      @(negedge clk);
      ref_edge = 1'b0; fb_edge = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 reset state", 1'b0);
  endtask

  task automatic t_lock_normal;
    do_reset(1'b0);
    pair(1'b1, 3);
    pair(1'b0, 0);
    check("R3 two good pairs", 1'b0);
    pair(1'b0, 3);
    check("R3 R2 three good pairs", 1'b1);
  endtask

  task automatic t_lock_precise;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) pair(i[0], 2);
    check("R4 four good pairs", 1'b0);
    pair(1'b1, 1);
    check("R4 five good pairs", 1'b1);
  endtask

  task automatic t_run_reset;
    do_reset(1'b0);
    pair(1'b1, 1);
    pair(1'b1, 1);
    pair(1'b0, 4);
    pair(1'b1, 1);
    pair(1'b1, 1);
    check("R5 R2 run restarted by err=4", 1'b0);
    pair(1'b1, 1);
    check("R5 fresh run complete", 1'b1);
  endtask

  task automatic t_hold_and_drop;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) pair(1'b1, 0);
    pair(1'b1, 6);
    pair(1'b0, 6);
    pair(1'b1, 4);
    check("R7 mid errors keep lock", 1'b1);
    pair(1'b0, 7);
    check("R6 R2 err=7 clears lock", 1'b0);
    pair(1'b1, 1);
    pair(1'b1, 1);
    check("R10 two good after unlock", 1'b0);
    pair(1'b1, 1);
    check("R10 relock after full run", 1'b1);
  endtask

  task automatic t_timeout;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) pair(1'b0, 2);
    @(negedge clk);
    ref_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
    repeat (20) @(negedge clk);
    check("R8 still locked before timeout", 1'b1);
    repeat (20) @(negedge clk);
    check("R8 missing partner clears lock", 1'b0);
  endtask

  task automatic t_repeat;
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) pair(1'b1, 2);
    @(negedge clk);
    fb_edge = 1'b1;
    @(negedge clk);
    fb_edge = 1'b0;
    repeat (2) @(negedge clk);
    fb_edge = 1'b1;
    @(negedge clk);
    fb_edge = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 repeated leader clears lock", 1'b0);
    repeat (40) @(negedge clk);
    pair(1'b1, 1);
    pair(1'b1, 1);
    check("R9 second pulse began no pair", 1'b0);
  endtask

  initial begin
    t_reset();
    t_lock_normal();
    t_lock_precise();
    t_run_reset();
    t_hold_and_drop();
    t_timeout();
    t_repeat();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule